// File: doc/BRIEF.md
# Ordered Store Buffer with Supervised-Load Blocking and Exception Dump

This block sits between a processor's store retirement path and the memory write port. Retired stores enter a small queue and are written to memory strictly oldest first, one per write handshake. Loads consult the queue through a combinational lookup. An ordinary load that matches a queued store takes the data of the youngest matching entry. An ordinary load with no match is directed to memory. A supervised load is never satisfied from the queue: while any store to its address is still queued, the lookup tells the core to stall.

Every entry carries the virtual address next to the physical address and data, so that queued stores can be reported to software. When the core signals a late supervised exception, the queue stops writing to memory and refuses new stores. It then hands out every queued entry, oldest first, on a separate readout port for a deferred handler. It ends with a one-cycle completion pulse and returns to normal operation with an empty queue. A barrier request is acknowledged only while the queue is empty.

Top module: `tso_sbuf`

## Requirements
- R1: Queued stores leave on the memory write port oldest first, one entry per cycle in which `mem_wr_valid` and `mem_wr_ready` are both high. While `mem_wr_ready` is low, the presented address and data hold steady.
- R2: An ordinary load (`ld_super`=0) whose physical address equals that of one or more queued entries gives `ld_fwd`=1, `ld_mem`=0 and `ld_fwd_data` equal to the data of the youngest such entry.
- R3: An ordinary load that matches no queued entry gives `ld_mem`=1 and `ld_fwd`=0.
- R4: A supervised load (`ld_super`=1) that matches a queued entry gives `ld_stall`=1, `ld_fwd`=0 and `ld_mem`=0. Once every matching entry has drained, the same load gives `ld_stall`=0 and `ld_mem`=1.
- R5: The queue holds 4 entries. With 4 entries queued `st_ready` is 0, and a store offered then is not stored: it never appears on the write port and it is not forwarded.
- R6: `bar_ack` is high only while `bar_req` is high and the queue is empty.
- R7: In the cycle after `exc_late` is sampled high, `mem_wr_valid` and `st_ready` are 0. The readout port then presents the queued entries oldest first, each with its virtual address, physical address and data, advancing one entry per `dump_valid`/`dump_ready` handshake. Stores offered during the readout are refused.
- R8: `dump_done` is high for exactly one cycle: the cycle after the last readout handshake, or the cycle after `exc_late` if the queue was empty. In the following cycle the queue is empty, `st_ready` is 1 and `dump_valid` is 0.
- R9: After reset the queue is empty: `st_ready`=1, `mem_wr_valid`=0, `dump_valid`=0, `dump_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Retired store offered |
| st_ready | output | 1 | Store accepted this cycle |
| st_vaddr | input | 40 | Store virtual address |
| st_paddr | input | 32 | Store physical address |
| st_data | input | 32 | Store data |
| ld_valid | input | 1 | Load lookup request |
| ld_super | input | 1 | Lookup is for a supervised load |
| ld_paddr | input | 32 | Load physical address |
| ld_fwd | output | 1 | Load satisfied from the queue |
| ld_fwd_data | output | 32 | Forwarded data |
| ld_mem | output | 1 | Load may read memory |
| ld_stall | output | 1 | Supervised load must wait |
| mem_wr_valid | output | 1 | Oldest entry offered to memory |
| mem_wr_ready | input | 1 | Memory takes the write |
| mem_wr_paddr | output | 32 | Write physical address |
| mem_wr_data | output | 32 | Write data |
| bar_req | input | 1 | Barrier request |
| bar_ack | output | 1 | Barrier may complete |
| exc_late | input | 1 | Late supervised exception pulse |
| dump_valid | output | 1 | Readout entry presented |
| dump_ready | input | 1 | Handler takes the entry |
| dump_vaddr | output | 40 | Readout virtual address |
| dump_paddr | output | 32 | Readout physical address |
| dump_data | output | 32 | Readout data |
| dump_done | output | 1 | Readout complete pulse |

## Verification
The assertions assume that `exc_late` is a single-cycle pulse raised only while no readout is in progress. They also assume that a load request is held for a full cycle with a stable address. The bench raises `exc_late` for exactly one cycle outside a readout. It drives every request on the falling edge and releases it after the next rising edge. Store offers are made while the queue is full or during a readout only to observe that they are refused, never to expect them to be taken.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    parameter int VA_W   = 40;
    parameter int PA_W   = 32;
    parameter int DATA_W = 32;

    typedef struct packed {
        logic [VA_W-1:0]   vaddr;
        logic [PA_W-1:0]   paddr;
        logic [DATA_W-1:0] data;
    } sb_entry_t;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_DUMP = 1'b1
    } sb_mode_t;

    function automatic logic same_line(input logic [PA_W-1:0] a, input logic [PA_W-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  sb_entry_t                     push_ent,
    input  logic                          pop,
    output sb_entry_t                     head_ent,
    output sb_entry_t [DEPTH-1:0]         age_ent,
    output logic      [DEPTH-1:0]         age_vld,
    output logic                          empty,
    output logic                          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    sb_entry_t             slots [DEPTH];
    logic [PTR_W-1:0]      head_q, tail_q;
    logic [CNT_W-1:0]      count_q;

    assign empty    = (count_q == '0);
    assign full     = (count_q == CNT_W'(DEPTH));
    assign head_ent = slots[head_q];

    // age-ordered view: position 0 is the oldest entry
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_age
            assign age_ent[i] = slots[head_q + PTR_W'(i)];
            assign age_vld[i] = (CNT_W'(i) < count_q);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) slots[tail_q] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + PTR_W'(1);
            if (pop)  head_q <= head_q + PTR_W'(1);
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // R5: never written while holding DEPTH entries
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R1: never read while empty
    p_no_underflow_r1: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (count_q == $past(count_q) - CNT_W'(1)));
endmodule

// File: rtl/sbuf_match.sv
module sbuf_match
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  sb_entry_t [DEPTH-1:0] age_ent,
    input  logic      [DEPTH-1:0] age_vld,
    input  logic [PA_W-1:0]       look_paddr,
    output logic                  hit,
    output logic [DATA_W-1:0]     hit_data
);
    logic [DEPTH-1:0] match;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
            assign match[i] = age_vld[i] && same_line(age_ent[i].paddr, look_paddr);
        end
    endgenerate

    // later positions are younger, so the last match wins
    always_comb begin
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_data = age_ent[i].data;
        end
    end

    assign hit = |match;
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
    import sbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic exc_late,
    input  logic empty,
    output logic dumping,
    output logic dump_done
);
    sb_mode_t mode_q;

    assign dumping   = (mode_q == MODE_DUMP);
    assign dump_done = dumping && empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RUN;
        end else begin
            case (mode_q)
                MODE_RUN:  if (exc_late) mode_q <= MODE_DUMP;
                MODE_DUMP: if (empty)    mode_q <= MODE_RUN;
                default:   mode_q <= MODE_RUN;
            endcase
        end
    end

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst) dump_done |=> !dump_done);
    // R7: an exception in run mode always starts a readout
    p_exc_enters_dump_r7: assert property (@(posedge clk) disable iff (rst)
        (exc_late && !dumping) |=> dumping);
endmodule

// File: rtl/tso_sbuf.sv
module tso_sbuf
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [VA_W-1:0]   st_vaddr,
    input  logic [PA_W-1:0]   st_paddr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              ld_valid,
    input  logic              ld_super,
    input  logic [PA_W-1:0]   ld_paddr,
    output logic              ld_fwd,
    output logic [DATA_W-1:0] ld_fwd_data,
    output logic              ld_mem,
    output logic              ld_stall,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [PA_W-1:0]   mem_wr_paddr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              bar_req,
    output logic              bar_ack,
    input  logic              exc_late,
    output logic              dump_valid,
    input  logic              dump_ready,
    output logic [VA_W-1:0]   dump_vaddr,
    output logic [PA_W-1:0]   dump_paddr,
    output logic [DATA_W-1:0] dump_data,
    output logic              dump_done
);
    sb_entry_t             head_ent, new_ent;
    sb_entry_t [DEPTH-1:0] age_ent;
    logic      [DEPTH-1:0] age_vld;
    logic                  empty, full, dumping, push, pop, hit;

    assign new_ent = '{vaddr: st_vaddr, paddr: st_paddr, data: st_data};

    assign st_ready     = !dumping && !full;
    assign push         = st_valid && st_ready;
    assign mem_wr_valid = !dumping && !empty;
    assign dump_valid   = dumping && !empty;
    assign pop          = (mem_wr_valid && mem_wr_ready) || (dump_valid && dump_ready);

    assign mem_wr_paddr = head_ent.paddr;
    assign mem_wr_data  = head_ent.data;
    assign dump_vaddr   = head_ent.vaddr;
    assign dump_paddr   = head_ent.paddr;
    assign dump_data    = head_ent.data;

    assign bar_ack  = bar_req && empty;
    assign ld_fwd   = ld_valid && !ld_super && hit;
    assign ld_stall = ld_valid && ld_super && hit;
    assign ld_mem   = ld_valid && !hit;

    sbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_ent(new_ent), .pop(pop),
        .head_ent(head_ent), .age_ent(age_ent), .age_vld(age_vld),
        .empty(empty), .full(full)
    );

    sbuf_match #(.DEPTH(DEPTH)) u_match (
        .age_ent(age_ent), .age_vld(age_vld), .look_paddr(ld_paddr),
        .hit(hit), .hit_data(ld_fwd_data)
    );

    sbuf_ctrl u_ctrl (
        .clk(clk), .rst(rst), .exc_late(exc_late), .empty(empty),
        .dumping(dumping), .dump_done(dump_done)
    );

    // R4: a supervised load is never given queued data
    p_super_no_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_super) |-> !ld_fwd);
    // R1: a held write keeps its address and data
    p_write_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready && !exc_late) |=>
        (mem_wr_valid && $stable(mem_wr_paddr) && $stable(mem_wr_data)));
    // R7: draining and store intake stop after the exception
    p_exc_halts_r7: assert property (@(posedge clk) disable iff (rst)
        (exc_late && !dump_valid && !dump_done && st_ready) |=> (!mem_wr_valid && !st_ready));
    // R6: barrier only completes with nothing left to write
    p_bar_empty_r6: assert property (@(posedge clk) disable iff (rst)
        bar_ack |-> (!mem_wr_valid && !dump_valid));
    // R8: after completion the queue takes stores again
    p_done_resume_r8: assert property (@(posedge clk) disable iff (rst)
        dump_done |=> (st_ready && !dump_valid));
endmodule

// File: tb/tso_sbuf_tb.sv
module tso_sbuf_tb;
    logic clk = 1'b0;
    logic rst;
    logic st_valid, st_ready;
    logic [39:0] st_vaddr;
    logic [31:0] st_paddr, st_data;
    logic ld_valid, ld_super, ld_fwd, ld_mem, ld_stall;
    logic [31:0] ld_paddr, ld_fwd_data;
    logic mem_wr_valid, mem_wr_ready;
    logic [31:0] mem_wr_paddr, mem_wr_data;
    logic bar_req, bar_ack, exc_late;
    logic dump_valid, dump_ready, dump_done;
    logic [39:0] dump_vaddr;
    logic [31:0] dump_paddr, dump_data;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tso_sbuf u_dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_vaddr(st_vaddr), .st_paddr(st_paddr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_super(ld_super), .ld_paddr(ld_paddr),
        .ld_fwd(ld_fwd), .ld_fwd_data(ld_fwd_data), .ld_mem(ld_mem), .ld_stall(ld_stall),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_paddr(mem_wr_paddr), .mem_wr_data(mem_wr_data),
        .bar_req(bar_req), .bar_ack(bar_ack), .exc_late(exc_late),
        .dump_valid(dump_valid), .dump_ready(dump_ready), .dump_vaddr(dump_vaddr),
        .dump_paddr(dump_paddr), .dump_data(dump_data), .dump_done(dump_done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [39:0] va, input logic [31:0] pa, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_vaddr = va; st_paddr = pa; st_data = d;
        #1 check("R5 st_ready with room", st_ready, 1);
        @(posedge clk); #1 st_valid = 1'b0;
    endtask

    task automatic expect_write(input logic [31:0] pa, input logic [31:0] d);
        @(negedge clk);
        mem_wr_ready = 1'b1;
        #1;
        check("R1 mem_wr_valid", mem_wr_valid, 1);
        check("R1 write paddr order", mem_wr_paddr, pa);
        check("R1 write data order", mem_wr_data, d);
        @(posedge clk); #1 mem_wr_ready = 1'b0;
    endtask

    task automatic probe(input logic sup, input logic [31:0] pa,
                         input logic f, input logic m, input logic s, input logic [31:0] d, input string req);
        @(negedge clk);
        ld_valid = 1'b1; ld_super = sup; ld_paddr = pa;
        #1;
        check({req, " ld_fwd"}, ld_fwd, f);
        check({req, " ld_mem"}, ld_mem, m);
        check({req, " ld_stall"}, ld_stall, s);
        if (f) check({req, " ld_fwd_data"}, ld_fwd_data, d);
        @(posedge clk); #1 ld_valid = 1'b0;
    endtask

    task automatic pulse_exc();
        @(negedge clk);
        exc_late = 1'b1;
        @(posedge clk); #1 exc_late = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk); #1;
        check("R9 st_ready", st_ready, 1);
        check("R9 mem_wr_valid", mem_wr_valid, 0);
        check("R9 dump_valid", dump_valid, 0);
        check("R9 dump_done", dump_done, 0);
    endtask

    task automatic test_forward();
        push(40'h100, 32'h40, 32'h11);
        push(40'h104, 32'h80, 32'h22);
        push(40'h108, 32'h40, 32'h33);
        probe(0, 32'h40, 1, 0, 0, 32'h33, "R2 youngest forward");
        probe(0, 32'h80, 1, 0, 0, 32'h22, "R2 single forward");
        probe(0, 32'h44, 0, 1, 0, 0, "R3 miss");
        probe(1, 32'h40, 0, 0, 1, 0, "R4 super stall");
        probe(1, 32'h44, 0, 1, 0, 0, "R4 super miss");
        expect_write(32'h40, 32'h11);
        probe(1, 32'h40, 0, 0, 1, 0, "R4 stall while younger match queued");
        probe(0, 32'h40, 1, 0, 0, 32'h33, "R2 forward after partial drain");
        expect_write(32'h80, 32'h22);
        expect_write(32'h40, 32'h33);
        probe(1, 32'h40, 0, 1, 0, 0, "R4 stall released");
    endtask

    task automatic test_hold();
        push(40'h200, 32'h90, 32'h55);
        @(negedge clk); #1;
        check("R1 held valid", mem_wr_valid, 1);
        check("R1 held paddr", mem_wr_paddr, 32'h90);
        @(negedge clk); #1;
        check("R1 still held", mem_wr_data, 32'h55);
        expect_write(32'h90, 32'h55);
        @(negedge clk); #1 check("R1 empty after drain", mem_wr_valid, 0);
    endtask

    task automatic test_full();
        for (int i = 0; i < 4; i++) push(40'h300 + 40'(i), 32'h10 + 32'(i), 32'hA0 + 32'(i));
        @(negedge clk);
        st_valid = 1'b1; st_paddr = 32'h99; st_vaddr = 40'h399; st_data = 32'hBAD;
        #1 check("R5 st_ready when full", st_ready, 0);
        @(posedge clk); #1 st_valid = 1'b0;
        probe(0, 32'h99, 0, 1, 0, 0, "R5 refused store not forwarded");
        for (int i = 0; i < 4; i++) expect_write(32'h10 + 32'(i), 32'hA0 + 32'(i));
        @(negedge clk); #1 check("R5 refused store never written", mem_wr_valid, 0);
    endtask

    task automatic test_barrier();
        push(40'h400, 32'h20, 32'h77);
        @(negedge clk);
        bar_req = 1'b1;
        #1 check("R6 no ack while queued", bar_ack, 0);
        expect_write(32'h20, 32'h77);
        @(negedge clk); #1 check("R6 ack when empty", bar_ack, 1);
        bar_req = 1'b0;
    endtask

    task automatic test_dump();
        for (int i = 0; i < 3; i++) push(40'h5000 + 40'(i), 32'h60 + 32'(i), 32'hC0 + 32'(i));
        pulse_exc();
        @(negedge clk);
        mem_wr_ready = 1'b1;
        st_valid = 1'b1; st_paddr = 32'h77; st_vaddr = 40'h777; st_data = 32'hEE;
        #1;
        check("R7 drain stopped", mem_wr_valid, 0);
        check("R7 store refused", st_ready, 0);
        check("R7 dump_valid", dump_valid, 1);
        check("R7 first vaddr", dump_vaddr, 40'h5000);
        @(posedge clk); #1 st_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            dump_ready = 1'b1;
            #1;
            check("R7 dump_valid each", dump_valid, 1);
            check("R7 dump vaddr", dump_vaddr, 40'h5000 + 40'(i));
            check("R7 dump paddr", dump_paddr, 32'h60 + 32'(i));
            check("R7 dump data", dump_data, 32'hC0 + 32'(i));
            check("R8 no early done", dump_done, 0);
            @(posedge clk); #1 dump_ready = 1'b0;
        end
        @(negedge clk); #1;
        check("R8 done pulse", dump_done, 1);
        check("R8 dump_valid low at done", dump_valid, 0);
        check("R7 no drain during dump", mem_wr_valid, 0);
        @(negedge clk); #1;
        check("R8 done single cycle", dump_done, 0);
        check("R8 st_ready restored", st_ready, 1);
        check("R8 buffer empty", mem_wr_valid, 0);
        mem_wr_ready = 1'b0;
    endtask

    task automatic test_dump_empty();
        pulse_exc();
        @(negedge clk); #1 check("R8 done on empty buffer", dump_done, 1);
        @(negedge clk); #1;
        check("R8 empty done single", dump_done, 0);
        check("R8 empty st_ready", st_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; st_valid = 0; st_vaddr = 0; st_paddr = 0; st_data = 0;
        ld_valid = 0; ld_super = 0; ld_paddr = 0; mem_wr_ready = 0;
        bar_req = 0; exc_late = 0; dump_ready = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        test_forward();
        test_hold();
        test_full();
        test_barrier();
        test_dump();
        test_dump_empty();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule